// File: doc/BRIEF.md
# Four-Channel Servo Pulse Timer

This block generates up to four servo control pulses from a single shared microsecond counter. A prescaler divides the system clock down to a one-microsecond tick. The counter runs from zero up to the active period value and then wraps. Each channel output stays high for as long as the count is below that channel's compare value. Software-style write ports let the user set an update rate in hertz and a pulse width per channel in microseconds. The rate is turned into a period value by an internal iterative divider.

Period and width writes only reach shadow copies. The live values are refreshed together at every counter wrap, and also on a forced update, which additionally clears the counter. Arming performs such a forced update and then starts counting. Disarming stops the counter at once and drives every output low, even if a pulse is in progress.

Top module: `servo_pwm_timer`

## Requirements
- R1: While armed, `count_o` advances by one every CLK_HZ/TICK_HZ clock cycles.
- R2: After reset the block is disarmed, `count_o` is 0, all outputs are low, and `period_o` equals TICK_HZ/50 (20000 at the default tick).
- R3: A rate request of 1 to 10000 Hz sets `rate_busy_o`. When it drops, the shadow period holds floor(TICK_HZ/rate). `period_o`, which shows the active period, keeps its old value until the next update event.
- R4: A rate request of 0, above 10000, or while `rate_busy_o` is high is discarded. It pulses `rate_err_o` high for exactly one cycle and leaves both the active and the shadow period unchanged.
- R5: The counter counts 0, 1, ..., `period_o` and then wraps to 0, so one period lasts `period_o`+1 ticks. Every wrap copies all shadow values into the active set.
- R6: Output i is high exactly while the block is armed, mask bit i is set, and `count_o` is below compare i. A compare above `period_o` keeps the output high for the whole period.
- R7: Writing a width N to channel i stores compare N-1, or 0 when N is 0. `rd_width_o` returns the stored compare of channel `rd_ch_i` plus one, and returns 0 for an index of NUM_CH or higher.
- R8: A width write never changes an output before the next update event.
- R9: A pulse on `upd_i` clears the counter to 0 and copies all shadow values into the active set, whether the block is armed or not.
- R10: A pulse on `arm_i` performs the same update as R9 and then starts the counter.
- R11: A pulse on `disarm_i` drives all outputs low and freezes `count_o` from the next cycle on. When `disarm_i` and `arm_i` are both high, disarm wins.
- R12: Output i stays low whenever bit i of `ch_mask_i` is 0.
- R13: A width write to channel index NUM_CH or higher changes no stored value and raises `ch_err_o` for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_i | input | 1 | Forced update, then start counting |
| disarm_i | input | 1 | Stop counter and force outputs low |
| upd_i | input | 1 | Forced update: clear counter, load shadows |
| ch_mask_i | input | NUM_CH | Per-channel output enable |
| wr_i | input | 1 | Width write strobe |
| wr_ch_i | input | CHS_W | Channel index of the width write |
| wr_width_i | input | CNT_W | Pulse width in microseconds |
| rd_ch_i | input | CHS_W | Channel index for width read-back |
| rd_width_o | output | CNT_W | Stored compare of `rd_ch_i` plus one |
| rate_we_i | input | 1 | Rate request strobe |
| rate_hz_i | input | RATE_W | Requested update rate in Hz |
| rate_busy_o | output | 1 | Rate-to-period division in progress |
| rate_err_o | output | 1 | One-cycle flag for a rejected rate request |
| ch_err_o | output | 1 | One-cycle flag for a bad channel index |
| period_o | output | CNT_W | Active period value |
| count_o | output | CNT_W | Current counter value |
| pwm_o | output | NUM_CH | Servo pulse outputs |

## Verification
The bench builds the block with CLK_HZ at 4 MHz and the standard 1 MHz tick, so each count lasts four clocks. A 10 kHz or 5 kHz period therefore completes in a few hundred cycles, and whole-period pulse lengths can be measured clock by clock. NUM_CH stays at 4 with a three-bit index, so indices 4 to 7 exercise the out-of-range paths. The rate limits stay at their defaults, so the 1 Hz and 3 Hz extremes show full-width divider results without a period ever having to run to completion.

// File: rtl/svt_pkg.sv
package svt_pkg;
    localparam int unsigned TICK_HZ_STD = 1_000_000;
    localparam int unsigned RATE_LO     = 1;
    localparam int unsigned RATE_HI     = 10_000;
    localparam int unsigned RATE_BOOT   = 50;

    // index width that never collapses to zero bits
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/svt_tick_gen.sv
module svt_tick_gen #(
    parameter int unsigned DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic clr_i,
    output logic tick_o
);
    localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)
            cnt_d = '0;
        else if (en_i)
            cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick_o = en_i && !clr_i && (cnt_q == LAST);
endmodule

// File: rtl/svt_rate_div.sv
module svt_rate_div #(
    parameter int unsigned NUM   = 1_000_000,
    parameter int unsigned NUM_W = 20,
    parameter int unsigned DEN_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [DEN_W-1:0] den_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [NUM_W-1:0] quo_o
);
    localparam int unsigned SW = $clog2(NUM_W + 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [SW-1:0]    step;
        logic [DEN_W-1:0] den;
        logic [DEN_W-1:0] rem;
        logic [NUM_W-1:0] quo;
    } div_t;

    div_t d, q;
    logic [DEN_W:0] shifted;

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        shifted = {q.rem, q.quo[NUM_W-1]};
        if (start_i && !q.busy) begin
            d.busy = 1'b1;
            d.step = SW'(NUM_W);
            d.den  = den_i;
            d.rem  = '0;
            d.quo  = NUM_W'(NUM);
        end else if (q.busy) begin
            if (shifted >= {1'b0, q.den}) begin
                d.rem = DEN_W'(shifted - {1'b0, q.den});
                d.quo = {q.quo[NUM_W-2:0], 1'b1};
            end else begin
                d.rem = shifted[DEN_W-1:0];
                d.quo = {q.quo[NUM_W-2:0], 1'b0};
            end
            d.step = q.step - 1'b1;
            if (q.step == SW'(1)) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o = q.busy;
    assign done_o = q.done;
    assign quo_o  = q.quo;
endmodule

// File: rtl/svt_chan_cmp.sv
module svt_chan_cmp #(
    parameter int unsigned CW = 20
) (
    input  logic          en_i,
    input  logic [CW-1:0] cnt_i,
    input  logic [CW-1:0] cmp_i,
    output logic          pwm_o
);
    assign pwm_o = en_i && (cnt_i < cmp_i);
endmodule

// File: rtl/servo_pwm_timer.sv
module servo_pwm_timer
    import svt_pkg::*;
#(
    parameter int unsigned CLK_HZ   = 50_000_000,
    parameter int unsigned TICK_HZ  = TICK_HZ_STD,
    parameter int unsigned NUM_CH   = 4,
    parameter int unsigned RATE_MIN = RATE_LO,
    parameter int unsigned RATE_MAX = RATE_HI,
    parameter int unsigned RATE_DEF = RATE_BOOT,
    localparam int unsigned CNT_W   = $clog2(TICK_HZ / RATE_MIN + 1),
    localparam int unsigned RATE_W  = $clog2(RATE_MAX + 1),
    localparam int unsigned IDX_W   = idx_width(NUM_CH),
    localparam int unsigned CHS_W   = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic              disarm_i,
    input  logic              upd_i,
    input  logic [NUM_CH-1:0] ch_mask_i,
    input  logic              wr_i,
    input  logic [CHS_W-1:0]  wr_ch_i,
    input  logic [CNT_W-1:0]  wr_width_i,
    input  logic [CHS_W-1:0]  rd_ch_i,
    output logic [CNT_W-1:0]  rd_width_o,
    input  logic              rate_we_i,
    input  logic [RATE_W-1:0] rate_hz_i,
    output logic              rate_busy_o,
    output logic              rate_err_o,
    output logic              ch_err_o,
    output logic [CNT_W-1:0]  period_o,
    output logic [CNT_W-1:0]  count_o,
    output logic [NUM_CH-1:0] pwm_o
);
    localparam int unsigned PRE_DIV = CLK_HZ / TICK_HZ;
    localparam int unsigned NUM_W   = $clog2(TICK_HZ + 1);
    localparam logic [CNT_W-1:0] PER_BOOT = CNT_W'(TICK_HZ / RATE_DEF);

    typedef struct packed {
        logic                         armed;
        logic                         ch_err;
        logic                         rate_err;
        logic [CNT_W-1:0]             cnt;
        logic [CNT_W-1:0]             per_act;
        logic [CNT_W-1:0]             per_sh;
        logic [NUM_CH-1:0][CNT_W-1:0] cmp_act;
        logic [NUM_CH-1:0][CNT_W-1:0] cmp_sh;
    } tmr_t;

    tmr_t d, q;

    logic             tick;
    logic             arm_go;
    logic             force_upd;
    logic             rate_ok;
    logic             div_start;
    logic             div_busy;
    logic             div_done;
    logic [NUM_W-1:0] div_quo;

    assign arm_go    = arm_i && !disarm_i;
    assign force_upd = upd_i || arm_go;
    assign rate_ok   = (rate_hz_i >= RATE_W'(RATE_MIN)) && (rate_hz_i <= RATE_W'(RATE_MAX));
    assign div_start = rate_we_i && rate_ok && !div_busy;

    svt_tick_gen #(.DIV(PRE_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (q.armed),
        .clr_i  (force_upd),
        .tick_o (tick)
    );

    svt_rate_div #(.NUM(TICK_HZ), .NUM_W(NUM_W), .DEN_W(RATE_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (div_start),
        .den_i   (rate_hz_i),
        .busy_o  (div_busy),
        .done_o  (div_done),
        .quo_o   (div_quo)
    );

    always_comb begin
        d          = q;
        d.ch_err   = 1'b0;
        d.rate_err = rate_we_i && !div_start;

        // shadow width write, stored minus one
        if (wr_i) begin
            if (wr_ch_i < CHS_W'(NUM_CH))
                d.cmp_sh[wr_ch_i[IDX_W-1:0]] = (wr_width_i == '0) ? '0 : wr_width_i - 1'b1;
            else
                d.ch_err = 1'b1;
        end

        if (div_done)
            d.per_sh = CNT_W'(div_quo);

        // counter and update events; writes of this cycle are included
        if (force_upd) begin
            d.cnt     = '0;
            d.per_act = d.per_sh;
            d.cmp_act = d.cmp_sh;
        end else if (tick && !disarm_i) begin
            if (q.cnt >= q.per_act) begin
                d.cnt     = '0;
                d.per_act = d.per_sh;
                d.cmp_act = d.cmp_sh;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end

        if (disarm_i)
            d.armed = 1'b0;
        else if (arm_i)
            d.armed = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q         <= '0;
            q.per_act <= PER_BOOT;
            q.per_sh  <= PER_BOOT;
        end else begin
            q <= d;
        end
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
        svt_chan_cmp #(.CW(CNT_W)) u_cmp (
            .en_i  (q.armed && ch_mask_i[i]),
            .cnt_i (q.cnt),
            .cmp_i (q.cmp_act[i]),
            .pwm_o (pwm_o[i])
        );
    end

    assign rd_width_o  = (rd_ch_i < CHS_W'(NUM_CH)) ? q.cmp_sh[rd_ch_i[IDX_W-1:0]] + 1'b1 : '0;
    assign rate_busy_o = div_busy;
    assign rate_err_o  = q.rate_err;
    assign ch_err_o    = q.ch_err;
    assign period_o    = q.per_act;
    assign count_o     = q.cnt;
endmodule

// File: rtl/servo_pwm_timer_chk.sv
module servo_pwm_timer_chk #(
    parameter int unsigned NUM_CH   = 4,
    parameter int unsigned CW       = 20,
    parameter int unsigned RW       = 14,
    parameter int unsigned SW       = 3,
    parameter int unsigned RATE_MIN = 1,
    parameter int unsigned RATE_MAX = 10_000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              disarm_i,
    input logic              upd_i,
    input logic [NUM_CH-1:0] ch_mask_i,
    input logic              wr_i,
    input logic [SW-1:0]     wr_ch_i,
    input logic              rate_we_i,
    input logic [RW-1:0]     rate_hz_i,
    input logic              rate_busy_o,
    input logic              rate_err_o,
    input logic              ch_err_o,
    input logic [CW-1:0]     period_o,
    input logic [CW-1:0]     count_o,
    input logic [NUM_CH-1:0] pwm_o
);
    // R11
    disarm_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disarm_i |=> (pwm_o == '0));

    // R11
    disarm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disarm_i && !upd_i) |=> (count_o == $past(count_o)));

    // R12
    mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pwm_o & ~ch_mask_i) == '0));

    // R13
    bad_ch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && (wr_ch_i >= SW'(NUM_CH))) |=> ch_err_o);

    // R13
    ch_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ch_err_o) |-> $past(wr_i));

    // R4
    rate_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_we_i && ((rate_hz_i < RW'(RATE_MIN)) || (rate_hz_i > RW'(RATE_MAX)))) |=> rate_err_o);

    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= period_o);

    // R9
    upd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_i |=> (count_o == '0));

    // R3
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rate_busy_o) |-> $past(rate_we_i));
endmodule

bind servo_pwm_timer servo_pwm_timer_chk #(
    .NUM_CH   (NUM_CH),
    .CW       (CNT_W),
    .RW       (RATE_W),
    .SW       (CHS_W),
    .RATE_MIN (RATE_MIN),
    .RATE_MAX (RATE_MAX)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .disarm_i    (disarm_i),
    .upd_i       (upd_i),
    .ch_mask_i   (ch_mask_i),
    .wr_i        (wr_i),
    .wr_ch_i     (wr_ch_i),
    .rate_we_i   (rate_we_i),
    .rate_hz_i   (rate_hz_i),
    .rate_busy_o (rate_busy_o),
    .rate_err_o  (rate_err_o),
    .ch_err_o    (ch_err_o),
    .period_o    (period_o),
    .count_o     (count_o),
    .pwm_o       (pwm_o)
);

// File: tb/servo_pwm_timer_test.sv
module servo_pwm_timer_test;
    localparam int NCH = 4;
    localparam int CW  = 20;
    localparam int RW  = 14;
    localparam int SW  = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           arm_i = 1'b0, disarm_i = 1'b0, upd_i = 1'b0;
    logic [NCH-1:0] ch_mask_i = 4'b1011;
    logic           wr_i = 1'b0;
    logic [SW-1:0]  wr_ch_i = '0;
    logic [CW-1:0]  wr_width_i = '0;
    logic [SW-1:0]  rd_ch_i = '0;
    logic [CW-1:0]  rd_width_o;
    logic           rate_we_i = 1'b0;
    logic [RW-1:0]  rate_hz_i = '0;
    logic           rate_busy_o, rate_err_o, ch_err_o;
    logic [CW-1:0]  period_o, count_o;
    logic [NCH-1:0] pwm_o;

    always #5 clk = ~clk;

    servo_pwm_timer #(.CLK_HZ(4_000_000), .TICK_HZ(1_000_000), .NUM_CH(NCH)) uut (
        .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .disarm_i(disarm_i), .upd_i(upd_i),
        .ch_mask_i(ch_mask_i), .wr_i(wr_i), .wr_ch_i(wr_ch_i), .wr_width_i(wr_width_i),
        .rd_ch_i(rd_ch_i), .rd_width_o(rd_width_o), .rate_we_i(rate_we_i),
        .rate_hz_i(rate_hz_i), .rate_busy_o(rate_busy_o), .rate_err_o(rate_err_o),
        .ch_err_o(ch_err_o), .period_o(period_o), .count_o(count_o), .pwm_o(pwm_o)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // scoreboard: ch==NCH means period length in clocks
    typedef struct { int ch; int val; string req; } item_t;
    item_t sb_q[$];
    bit    meas_req = 1'b0;

    task automatic push(int ch, int val, string req);
        item_t it;
        it.ch = ch; it.val = val; it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic expect_period(int h0, int h1, int h2, int h3, int len);
        push(0, h0, "R6 ch0 high clocks");
        push(1, h1, "R6 ch1 high clocks");
        push(2, h2, "R12 masked ch2 high clocks");
        push(3, h3, "R6 ch3 high clocks");
        push(NCH, len, "R5 period clocks");
        meas_req = 1'b1;
        wait (meas_req == 1'b0);
    endtask

    // monitor: measures one full period starting at the next wrap
    initial begin
        int hi[NCH];
        int len, prev;
        bit w;
        item_t it;
        forever begin
            @(negedge clk);
            if (meas_req) begin
                prev = int'(count_o);
                w = 1'b0;
                while (!w) begin
                    @(negedge clk);
                    w = (count_o == 0) && (prev != 0);
                    prev = int'(count_o);
                end
                for (int k = 0; k < NCH; k++) hi[k] = 0;
                len = 0;
                w = 1'b0;
                while (!w) begin
                    for (int k = 0; k < NCH; k++) hi[k] += int'(pwm_o[k]);
                    len++;
                    @(negedge clk);
                    w = (count_o == 0) && (prev != 0);
                    prev = int'(count_o);
                end
                while (sb_q.size() > 0) begin
                    it = sb_q.pop_front();
                    chk(it.req, (it.ch == NCH) ? len : hi[it.ch], it.val);
                end
                meas_req = 1'b0;
            end
        end
    end

    task automatic write_w(int ch, int w);
        @(negedge clk);
        wr_i = 1'b1; wr_ch_i = SW'(ch); wr_width_i = CW'(w);
        @(negedge clk);
        wr_i = 1'b0;
    endtask

    task automatic read_w(int ch, output int v);
        rd_ch_i = SW'(ch);
        #1;
        v = int'(rd_width_o);
    endtask

    task automatic set_rate(int r);
        @(negedge clk);
        rate_we_i = 1'b1; rate_hz_i = RW'(r);
        @(negedge clk);
        rate_we_i = 1'b0;
    endtask

    task automatic wait_div;
        while (rate_busy_o) @(negedge clk);
    endtask

    task automatic pulse_upd;
        @(negedge clk) upd_i = 1'b1;
        @(negedge clk) upd_i = 1'b0;
    endtask

    task automatic pulse_arm;
        @(negedge clk) arm_i = 1'b1;
        @(negedge clk) arm_i = 1'b0;
    endtask

    task automatic wait_count(int c);
        while (int'(count_o) != c) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #3_000_000;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int v, n, c0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state
        chk("R2 period after reset", period_o, 20000);
        chk("R2 count after reset", count_o, 0);
        chk("R2 outputs after reset", pwm_o, 0);

        // R4 out-of-range rates
        set_rate(0);
        chk("R4 err for rate 0", rate_err_o, 1);
        @(negedge clk);
        chk("R4 err one cycle", rate_err_o, 0);
        set_rate(10001);
        chk("R4 err for rate 10001", rate_err_o, 1);
        chk("R4 busy stays low", rate_busy_o, 0);

        // R3 valid rate; second request while busy is R4
        set_rate(10000);
        chk("R3 busy after valid rate", rate_busy_o, 1);
        chk("R3 no err on valid rate", rate_err_o, 0);
        set_rate(20);
        chk("R4 err while busy", rate_err_o, 1);
        wait_div();
        chk("R3 active period unchanged", period_o, 20000);
        pulse_upd();
        chk("R9 period loaded by update", period_o, 100);
        chk("R9 count cleared", count_o, 0);

        // R7 width encoding and read-back
        write_w(0, 31);
        write_w(1, 0);
        write_w(2, 50);
        write_w(3, 200);
        read_w(0, v); chk("R7 read ch0", v, 31);
        read_w(1, v); chk("R7 read width 0", v, 1);
        read_w(3, v); chk("R7 read ch3", v, 200);
        read_w(5, v); chk("R7 read bad index", v, 0);
        write_w(1, 1);
        read_w(1, v); chk("R7 read width 1", v, 1);

        // R13 bad channel write
        write_w(5, 77);
        chk("R13 ch_err raised", ch_err_o, 1);
        @(negedge clk);
        chk("R13 ch_err one cycle", ch_err_o, 0);
        read_w(0, v); chk("R13 ch0 untouched", v, 31);
        read_w(2, v); chk("R13 ch2 untouched", v, 50);
        read_w(3, v); chk("R13 ch3 untouched", v, 200);
        chk("R6 outputs low while disarmed", pwm_o, 0);

        // R10 arm, R1 tick spacing
        pulse_arm();
        chk("R10 count zero at arm", count_o, 0);
        wait_count(1);
        n = 0;
        while (int'(count_o) == 1) begin @(negedge clk); n++; end
        chk("R1 clocks per count", n, 4);
        chk("R1 next count", count_o, 2);

        // R5 R6 R12 full period with P=100
        expect_period(120, 0, 0, 404, 404);

        // R8 preload: write mid-pulse, output unchanged
        wait_count(5);
        chk("R8 ch0 high before write", pwm_o[0], 1);
        write_w(0, 1);
        chk("R8 ch0 still high after write", pwm_o[0], 1);
        expect_period(0, 0, 0, 404, 404);

        // R3 R5 new rate applied at wrap
        set_rate(5000);
        wait_div();
        expect_period(0, 0, 0, 796, 804);
        chk("R5 period after wrap", period_o, 200);

        // R11 disarm freezes counter and outputs
        write_w(0, 41);
        wait_count(2);
        wait_count(10);
        @(negedge clk) disarm_i = 1'b1;
        c0 = int'(count_o);
        @(negedge clk) disarm_i = 1'b0;
        chk("R11 outputs low after disarm", pwm_o, 0);
        chk("R11 count frozen", count_o, c0);
        repeat (20) @(negedge clk);
        chk("R11 count still frozen", count_o, c0);
        @(negedge clk) begin arm_i = 1'b1; disarm_i = 1'b1; end
        @(negedge clk) begin arm_i = 1'b0; disarm_i = 1'b0; end
        repeat (10) @(negedge clk);
        chk("R11 disarm wins count", count_o, c0);
        chk("R11 disarm wins outputs", pwm_o, 0);

        // R10 re-arm restarts from zero with new widths
        pulse_arm();
        chk("R10 count zero at rearm", count_o, 0);
        chk("R6 ch0 high at count 0", pwm_o[0], 1);
        chk("R12 ch2 low while masked", pwm_o[2], 0);
        expect_period(160, 0, 0, 796, 804);

        // R3 divider extremes while disarmed
        @(negedge clk) disarm_i = 1'b1;
        @(negedge clk) disarm_i = 1'b0;
        set_rate(3);
        wait_div();
        pulse_upd();
        chk("R3 period for 3 Hz", period_o, 333333);
        set_rate(1);
        wait_div();
        pulse_upd();
        chk("R3 period for 1 Hz", period_o, 1000000);

        finish_run();
    end
endmodule